// File: doc/BRIEF.md
# Dual H-Bridge Motor Control Port

This block is a write-only command byte placed on a processor data bus. When the address decoder raises its select strobe, the byte on the bus is captured at the next clock edge. The captured byte then steers the switch gates of two H-bridges, one per bidirectional DC motor. Any bits the motors do not use appear unchanged on spare digital output pins.

Each motor has one enable bit and two direction bits. Each direction bit drives one leg of its bridge. A 1 turns that leg's high-side switch on. A 0 turns its low-side switch on. Because one bit sets both switches of a leg, the high and low switch of a leg are never on together. When enable is 0, every switch of the bridge is off.

Each motor is treated as a small state machine with five named states:
- MODE_COAST: disabled, all switches off.
- MODE_FWD: leg 0 high, leg 1 low.
- MODE_REV: leg 0 low, leg 1 high.
- MODE_BRAKE_HI: both legs on the upper rail.
- MODE_BRAKE_LO: both legs on the lower rail.

The state changes only on a strobed write, and any state may go directly to any other.
- The transition "drive" leaves MODE_COAST when enable is set.
- The transition "release" returns to MODE_COAST when enable is cleared.
- The transition "steer" moves among the four enabled states when the direction bits change.

Software sets speed by writing the byte again and again with the enable bit toggled, which moves the motor between drive and release.

Top module: `dual_hbridge_port`

## Requirements
- R1: An active-low synchronous reset clears the command byte, so every gate output and spare output is 0 after reset.
- R2: The byte on `wr_data` is captured at a rising clock edge where `wr_stb` is 1. Without the strobe, the captured byte and all outputs hold, whatever `wr_data` does.
- R3: Byte layout: bit 0 is the enable of motor 0, and bits 1 and 2 are its leg 0 and leg 1 direction. Bit 3 is the enable of motor 1, and bits 4 and 5 are its leg 0 and leg 1 direction. Bits 6 and 7 are spare. The gate index for motor m, leg l is 2*m+l.
- R4: With a motor's enable at 0 (MODE_COAST), all four of its gate outputs are 0.
- R5: Enabled with leg 0 direction 1 and leg 1 direction 0 (MODE_FWD), the motor drives `hi_gate` of leg 0 and `lo_gate` of leg 1. With 0 and 1 (MODE_REV), it drives `lo_gate` of leg 0 and `hi_gate` of leg 1. No other gate of that motor is on.
- R6: Enabled with both direction bits 1 (MODE_BRAKE_HI), both high gates are on and both low gates are off. With both direction bits 0 (MODE_BRAKE_LO), both low gates are on and both high gates are off.
- R7: For every leg, `hi_gate` and `lo_gate` are never 1 at the same time.
- R8: Bits 6 and 7 of the captured byte appear on `spare_out[0]` and `spare_out[1]`, and they have no effect on any gate.
- R9: The gates of one motor depend only on that motor's three bits.
- R10: Rewriting the byte with only the enable bit toggled alternates the motor between its driving state and MODE_COAST, and the direction is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Decode strobe; captures `wr_data` at the clock edge |
| wr_data | input | 8 | Data bus byte |
| hi_gate | output | 4 | High-side switch controls, index 2*motor+leg |
| lo_gate | output | 4 | Low-side switch controls, index 2*motor+leg |
| spare_out | output | 2 | Spare digital outputs |

## Verification
The bench writes all 256 byte values. After each write it checks every gate against the mode that the requirements predict, and it checks every leg for shoot-through. A design that mapped direction to the wrong leg would swap forward and reverse. A design that ignored enable would drive a motor that should coast. A design that inverted only one side of a leg would turn both switches on. The other directed tests target the remaining failure modes. A write without the strobe would leak bus traffic into the motors. Spare bits wired into the gates would break R8. Crossed motor fields would break R9. A toggle that also cleared the direction would break R10.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

    typedef enum logic [2:0] {
        MODE_COAST    = 3'd0,
        MODE_FWD      = 3'd1,
        MODE_REV      = 3'd2,
        MODE_BRAKE_HI = 3'd3,
        MODE_BRAKE_LO = 3'd4
    } bridge_mode_e;

    localparam int FIELD_W = 3;   // enable + two leg directions per motor
    localparam int LEGS    = 2;

    typedef struct packed {
        logic [LEGS-1:0] dir;     // dir[l] steers leg l
        logic            en;
    } motor_field_t;

endpackage

// File: rtl/mctl_cmd_reg.sv
module mctl_cmd_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/mctl_bridge.sv
module mctl_bridge
    import mctl_pkg::*;
(
    input  motor_field_t       field,
    output bridge_mode_e       mode,
    output logic [LEGS-1:0]    hi,
    output logic [LEGS-1:0]    lo
);

    // State decode from the captured command bits
    always_comb begin
        if (!field.en) begin
            mode = MODE_COAST;
        end else begin
            unique case (field.dir)
                2'b01:   mode = MODE_FWD;
                2'b10:   mode = MODE_REV;
                2'b11:   mode = MODE_BRAKE_HI;
                default: mode = MODE_BRAKE_LO;
            endcase
        end
    end

    // Gate outputs per state; each leg is driven as a complementary pair
    always_comb begin
        hi = '0;
        lo = '0;
        unique case (mode)
            MODE_COAST: begin
                hi = 2'b00;
                lo = 2'b00;
            end
            MODE_FWD: begin
                hi = 2'b01;
                lo = 2'b10;
            end
            MODE_REV: begin
                hi = 2'b10;
                lo = 2'b01;
            end
            MODE_BRAKE_HI: begin
                hi = 2'b11;
                lo = 2'b00;
            end
            MODE_BRAKE_LO: begin
                hi = 2'b00;
                lo = 2'b11;
            end
            default: begin
                hi = 2'b00;
                lo = 2'b00;
            end
        endcase
    end

endmodule

// File: rtl/dual_hbridge_port.sv
module dual_hbridge_port
    import mctl_pkg::*;
#(
    parameter int MOTORS  = 2,
    parameter int SPARE_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_stb,
    input  logic [FIELD_W*MOTORS+SPARE_W-1:0] wr_data,
    output logic [LEGS*MOTORS-1:0]         hi_gate,
    output logic [LEGS*MOTORS-1:0]         lo_gate,
    output logic [SPARE_W-1:0]             spare_out
);

    localparam int MOTOR_BITS = FIELD_W * MOTORS;
    localparam int DATA_W     = MOTOR_BITS + SPARE_W;
    localparam int GATES      = LEGS * MOTORS;

    logic [DATA_W-1:0] cmd_q;

    mctl_cmd_reg #(.WIDTH(DATA_W)) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (wr_stb),
        .d    (wr_data),
        .q    (cmd_q)
    );

    assign spare_out = cmd_q[DATA_W-1:MOTOR_BITS];

    // Capture and hold behaviour of the command byte
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (cmd_q == $past(wr_data)));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cmd_q));

    for (genvar m = 0; m < MOTORS; m++) begin : g_motor
        motor_field_t    fld;
        bridge_mode_e    mode;
        logic [LEGS-1:0] hi_m;
        logic [LEGS-1:0] lo_m;

        assign fld = motor_field_t'(cmd_q[FIELD_W*m +: FIELD_W]);

        mctl_bridge u_bridge (
            .field(fld),
            .mode (mode),
            .hi   (hi_m),
            .lo   (lo_m)
        );

        assign hi_gate[LEGS*m +: LEGS] = hi_m;
        assign lo_gate[LEGS*m +: LEGS] = lo_m;

        // Disabled motor coasts
        p_coast_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !cmd_q[FIELD_W*m] |-> (hi_gate[LEGS*m +: LEGS] == '0 &&
                                   lo_gate[LEGS*m +: LEGS] == '0));
        // Enabled with equal direction bits: both legs on one rail
        p_brake_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_q[FIELD_W*m] && (cmd_q[FIELD_W*m+1] == cmd_q[FIELD_W*m+2]))
            |-> (hi_gate[LEGS*m] == hi_gate[LEGS*m+1] &&
                 lo_gate[LEGS*m] == lo_gate[LEGS*m+1] &&
                 hi_gate[LEGS*m] != lo_gate[LEGS*m]));
        // Enabled with differing direction bits: exactly one high and one low
        p_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_q[FIELD_W*m] && (cmd_q[FIELD_W*m+1] != cmd_q[FIELD_W*m+2]))
            |-> ($countones(hi_gate[LEGS*m +: LEGS]) == 1 &&
                 $countones(lo_gate[LEGS*m +: LEGS]) == 1));
    end

    for (genvar k = 0; k < GATES; k++) begin : g_leg
        p_no_shoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(hi_gate[k] && lo_gate[k]));
    end

endmodule

// File: tb/sim_dual_hbridge_port.sv
module sim_dual_hbridge_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] hi_gate;
    logic [3:0] lo_gate;
    logic [1:0] spare_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dual_hbridge_port u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .hi_gate  (hi_gate),
        .lo_gate  (lo_gate),
        .spare_out(spare_out)
    );

    function automatic logic [3:0] exp_hi(logic [7:0] v);
        logic [3:0] r;
        for (int m = 0; m < 2; m++) begin
            r[2*m]   = v[3*m] & v[3*m+1];
            r[2*m+1] = v[3*m] & v[3*m+2];
        end
        return r;
    endfunction

    function automatic logic [3:0] exp_lo(logic [7:0] v);
        logic [3:0] r;
        for (int m = 0; m < 2; m++) begin
            r[2*m]   = v[3*m] & ~v[3*m+1];
            r[2*m+1] = v[3*m] & ~v[3*m+2];
        end
        return r;
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Strobed write; returns at the following falling edge, after the capture
    task automatic write_byte(logic [7:0] v);
        @(negedge clk);
        wr_data = v;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wr_data = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1", "hi", {4'h0, hi_gate}, 8'h00);
        chk("R1", "lo", {4'h0, lo_gate}, 8'h00);
        chk("R1", "spare", {6'h0, spare_out}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_all_codes;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = v[7:0];
            write_byte(b);
            for (int m = 0; m < 2; m++) begin
                string req;
                if (!b[3*m])                    req = "R4";
                else if (b[3*m+1] != b[3*m+2])  req = "R5";
                else                            req = "R6";
                chk(req, "hi", {6'h0, hi_gate[2*m +: 2]}, {6'h0, exp_hi(b)[2*m +: 2]});
                chk(req, "lo", {6'h0, lo_gate[2*m +: 2]}, {6'h0, exp_lo(b)[2*m +: 2]});
            end
            chk("R7", "overlap", {4'h0, hi_gate & lo_gate}, 8'h00);
            chk("R3", "spare", {6'h0, spare_out}, {6'h0, b[7:6]});
        end
    endtask

    task automatic t_hold;
        write_byte(8'b00_011_011);   // both motors forward... legs per R5
        @(negedge clk);
        wr_data = 8'b11_100_100;
        repeat (3) @(negedge clk);
        chk("R2", "hi hold", {4'h0, hi_gate}, {4'h0, exp_hi(8'b00_011_011)});
        chk("R2", "lo hold", {4'h0, lo_gate}, {4'h0, exp_lo(8'b00_011_011)});
        chk("R2", "spare hold", {6'h0, spare_out}, 8'h00);
    endtask

    task automatic t_spare;
        write_byte(8'b00_101_011);
        write_byte(8'b11_101_011);
        chk("R8", "spare", {6'h0, spare_out}, 8'h03);
        chk("R8", "hi", {4'h0, hi_gate}, {4'h0, exp_hi(8'b00_101_011)});
        chk("R8", "lo", {4'h0, lo_gate}, {4'h0, exp_lo(8'b00_101_011)});
        write_byte(8'b01_101_011);
        chk("R8", "spare bit0", {6'h0, spare_out}, 8'h01);
    endtask

    task automatic t_independent;
        // motor 0 forward fixed, motor 1 swept across all its codes
        for (int f = 0; f < 8; f++) begin
            logic [7:0] b;
            b = {2'b00, f[2:0], 3'b011};
            write_byte(b);
            chk("R9", "m0 hi", {6'h0, hi_gate[1:0]}, 8'h01);
            chk("R9", "m0 lo", {6'h0, lo_gate[1:0]}, 8'h02);
        end
    endtask

    task automatic t_pwm;
        // motor 1 reverse: en=1, leg0=0, leg1=1
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            b = {2'b00, 2'b10, i[0] ? 1'b0 : 1'b1, 3'b000};
            write_byte(b);
            if (i[0]) begin
                chk("R10", "off hi", {6'h0, hi_gate[3:2]}, 8'h00);
                chk("R10", "off lo", {6'h0, lo_gate[3:2]}, 8'h00);
            end else begin
                chk("R10", "on hi", {6'h0, hi_gate[3:2]}, 8'h02);
                chk("R10", "on lo", {6'h0, lo_gate[3:2]}, 8'h01);
            end
        end
    endtask

    initial begin
        t_reset();
        t_all_codes();
        t_hold();
        t_spare();
        t_independent();
        t_pwm();
        write_byte(8'hFF);
        t_reset();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule